// File: doc/BRIEF.md
# ALU Function Select Decoder

This block turns the coarse operation class issued by the main instruction decoder, together with the 6-bit function field of the current instruction, into the 4-bit code that steers the ALU. Memory accesses always get an add, so that the ALU can form an address from a base register and an offset. Conditional branches always get a subtract, so that equality follows from a zero result. Only register-to-register instructions look at the function field, which picks add, subtract, AND, OR or set-on-less-than.

Decoding works in two levels. The class is decoded into one-hot flags. The function field is matched separately against a table of known codes. A final selector combines the two results. The select is available combinationally in the same cycle. A copy registered on the clock is also provided, so that a surrounding pipeline stage or a bench can sample a stable value. Any function field outside the table, and the unused class code, give the add select. No input pattern leaves the output undefined.

Top module: `alu_sel_unit`

## Requirements
- R1: With `op_class` = 00 (memory access), `sel_now` is 0010 (add) whatever the value of `funct`.
- R2: With `op_class` = 01 (conditional branch), `sel_now` is 0110 (subtract) whatever the value of `funct`.
- R3: With `op_class` = 10 (register type), `funct` 100000 gives 0010 (add) and `funct` 100010 gives 0110 (subtract).
- R4: With `op_class` = 10, `funct` 100100 gives 0000 (AND) and `funct` 100101 gives 0001 (OR).
- R5: With `op_class` = 10, `funct` 101010 gives 0111 (set-on-less-than).
- R6: With `op_class` = 10, any `funct` outside the five codes above gives 0010 (add).
- R7: With `op_class` = 11 (unused), `sel_now` is 0010 (add) whatever the value of `funct`.
- R8: `sel_now` follows the inputs in the same cycle, with no register in its path.
- R9: While `rst_n` is low, `sel_q` is 0010. After each rising clock edge with `rst_n` high, `sel_q` holds the `sel_now` value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered copy of the select |
| rst_n | input | 1 | Active-low synchronous reset of the registered copy |
| op_class | input | 2 | Operation class from the main decoder |
| funct | input | 6 | Function field of the instruction |
| sel_now | output | 4 | Combinational ALU function select |
| sel_q | output | 4 | Select registered on the rising clock edge |

## Verification
The bench drives function fields that are valid register-type codes together with the memory and branch classes. A design that let the function field leak through for those classes would return AND or OR where an add or a subtract is needed. Codes that differ by one bit from a known code, such as 100001 or 101011, are aimed at a matcher that compares only some of the bits. Such a matcher would alias these codes onto a real operation instead of falling back to add. The unused class 11 is exercised on its own, so that a decoder that treats the upper class bit alone as register type is exposed. The registered output is checked one edge later, which catches an extra or a missing pipeline stage.

// File: rtl/alu_sel_pkg.sv
package alu_sel_pkg;

  localparam int CLASS_W = 2;
  localparam int FUNCT_W = 6;
  localparam int SEL_W   = 4;
  localparam int N_RTYPE = 5;

  typedef enum logic [CLASS_W-1:0] {
    CLS_MEM  = 2'b00,
    CLS_BR   = 2'b01,
    CLS_REG  = 2'b10,
    CLS_RSVD = 2'b11
  } op_class_e;

  localparam logic [SEL_W-1:0] SEL_AND = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_SLT = 4'b0111;

  // register-type table: entry i pairs a function code with its select
  localparam logic [N_RTYPE-1:0][FUNCT_W-1:0] FUNCT_TAB = {
    6'b101010, 6'b100101, 6'b100100, 6'b100010, 6'b100000
  };
  localparam logic [N_RTYPE-1:0][SEL_W-1:0] SEL_TAB = {
    SEL_SLT, SEL_OR, SEL_AND, SEL_SUB, SEL_ADD
  };

  // final pick: class flags override; register class uses the table result
  function automatic logic [SEL_W-1:0] pick_sel(
    input logic             reg_class,
    input logic             br_class,
    input logic             known,
    input logic [SEL_W-1:0] table_sel
  );
    if (br_class)               return SEL_SUB;
    else if (reg_class && known) return table_sel;
    else                        return SEL_ADD;
  endfunction

endpackage

// File: rtl/op_class_decode.sv
module op_class_decode
  import alu_sel_pkg::*;
(
  input  logic [CLASS_W-1:0] op_class,
  output logic               is_mem,
  output logic               is_br,
  output logic               is_reg,
  output logic               is_rsvd
);

  always_comb begin
    is_mem  = 1'b0;
    is_br   = 1'b0;
    is_reg  = 1'b0;
    is_rsvd = 1'b0;
    unique case (op_class_e'(op_class))
      CLS_MEM:  is_mem  = 1'b1;
      CLS_BR:   is_br   = 1'b1;
      CLS_REG:  is_reg  = 1'b1;
      CLS_RSVD: is_rsvd = 1'b1;
      default:  is_rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/funct_match.sv
module funct_match
  import alu_sel_pkg::*;
#(
  parameter int N_OPS = N_RTYPE,
  parameter int FW    = FUNCT_W,
  parameter int SW    = SEL_W
) (
  input  logic [FW-1:0]    funct,
  output logic [N_OPS-1:0] hit,
  output logic             known,
  output logic [SW-1:0]    table_sel
);

  logic [N_OPS-1:0][SW-1:0] masked;

  for (genvar i = 0; i < N_OPS; i++) begin : g_entry
    assign hit[i]    = (funct == FUNCT_TAB[i]);
    assign masked[i] = hit[i] ? SEL_TAB[i] : '0;
  end

  always_comb begin
    table_sel = '0;
    for (int k = 0; k < N_OPS; k++) table_sel = table_sel | masked[k];
  end

  assign known = |hit;

endmodule

// File: rtl/alu_sel_unit.sv
module alu_sel_unit
  import alu_sel_pkg::*;
#(
  parameter int CW = CLASS_W,
  parameter int FW = FUNCT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] op_class,
  input  logic [FW-1:0] funct,
  output logic [SW-1:0] sel_now,
  output logic [SW-1:0] sel_q
);

  logic               is_mem, is_br, is_reg, is_rsvd;
  logic [N_RTYPE-1:0] funct_hit;
  logic               funct_known;
  logic [SW-1:0]      table_sel;

  op_class_decode u_cls (
    .op_class (op_class),
    .is_mem   (is_mem),
    .is_br    (is_br),
    .is_reg   (is_reg),
    .is_rsvd  (is_rsvd)
  );

  funct_match #(.N_OPS(N_RTYPE), .FW(FW), .SW(SW)) u_fm (
    .funct     (funct),
    .hit       (funct_hit),
    .known     (funct_known),
    .table_sel (table_sel)
  );

  assign sel_now = pick_sel(is_reg, is_br, funct_known, table_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= SEL_ADD;
    else        sel_q <= sel_now;
  end

  // class flags from the decoder must be exactly one-hot
  assert_class_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_mem, is_br, is_reg, is_rsvd}) == 1);

  assert_mem_add_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b00) |-> (sel_now == 4'b0010));

  assert_br_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b01) |-> (sel_now == 4'b0110));

  assert_slt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b10 && funct == 6'b101010) |-> (sel_now == 4'b0111));

  assert_unknown_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_reg && !funct_known) |-> (sel_now == 4'b0010));

  assert_rsvd_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 2'b11) |-> (sel_now == 4'b0010));

  assert_hit_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(funct_hit));

  assert_reg_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (sel_q == $past(sel_now)));

endmodule

// File: tb/test_alu_sel_unit.sv
module test_alu_sel_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [5:0] funct = 6'b0;
  logic [3:0] sel_now, sel_q;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_sel_unit i_alu_sel_unit (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .funct(funct),
    .sel_now(sel_now), .sel_q(sel_q)
  );

  function automatic logic [3:0] ref_sel(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b01) return 4'b0110;
    if (c != 2'b10) return 4'b0010;
    case (f)
      6'd32:   return 4'b0010;
      6'd34:   return 4'b0110;
      6'd36:   return 4'b0000;
      6'd37:   return 4'b0001;
      6'd42:   return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] c, input logic [5:0] f);
    if (c == 2'b00) return "R1";
    if (c == 2'b01) return "R2";
    if (c == 2'b11) return "R7";
    if (f == 6'd32 || f == 6'd34) return "R3";
    if (f == 6'd36 || f == 6'd37) return "R4";
    if (f == 6'd42) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (class %b funct %b)", req, act, exp, op_class, funct);
    end
  endtask

  // one vector: comb result same half-cycle (R8), registered one edge later (R9)
  task automatic apply(input logic [1:0] c, input logic [5:0] f);
    logic [3:0] e;
    @(negedge clk);
    op_class = c;
    funct    = f;
    e = ref_sel(c, f);
    #1;
    check(req_of(c, f), sel_now, e);
    @(negedge clk);
    check("R9", sel_q, e);
  endtask

  initial begin
    #800000;
    $display("FAIL watchdog: got timeout expected completion");
    n_bad++;
    if (!done) begin
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] known [5] = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    op_class = 2'b10; funct = 6'd36;
    @(negedge clk);
    check("R9", sel_q, 4'b0010);
    rst_n = 1'b1;
    // R1 / R2 with register-type codes present: must not leak
    apply(2'b00, 6'd36);
    apply(2'b00, 6'd37);
    apply(2'b01, 6'd36);
    apply(2'b01, 6'd42);
    // R3 R4 R5 each code
    apply(2'b10, 6'd32);
    apply(2'b10, 6'd34);
    apply(2'b10, 6'd36);
    apply(2'b10, 6'd37);
    apply(2'b10, 6'd42);
    // R6 near misses
    apply(2'b10, 6'd33);
    apply(2'b10, 6'd43);
    apply(2'b10, 6'd4);
    apply(2'b10, 6'd0);
    apply(2'b10, 6'd63);
    // R7 unused class
    apply(2'b11, 6'd36);
    apply(2'b11, 6'd34);
    // R8 back-to-back change inside one cycle
    @(negedge clk);
    op_class = 2'b10; funct = 6'd37; #1;
    check("R8", sel_now, 4'b0001);
    funct = 6'd42; #1;
    check("R8", sel_now, 4'b0111);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      logic [5:0] f;
      c = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) f = known[$urandom_range(0, 4)];
      else                           f = 6'($urandom);
      apply(c, f);
    end
    // R9 reset returns the copy to add
    @(negedge clk);
    op_class = 2'b10; funct = 6'd36;
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", sel_q, 4'b0010);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule